// File: doc/BRIEF.md
# Trap Cause Flag Register

This block keeps a record of why the processor took a trap through the bus-error or address-error vector. The core's trap logic sends it one single-cycle strobe for each kind of event. The register turns those strobes into six sticky cause flags, which software reads on a 16-bit port. Any write by software clears all six flags. The data written does not matter, so the block has only a write-enable and no write-data port.

One flag needs special handling: the red-zone stack flag in bit 2. A static mode input picks the rule for it.

- **Strict mode** (`extMode` = 0): bit 2 records only real red-zone stack-limit violations. A fatal stack error that came from escalating some other abort does not set it. An escalation caused by memory management sets no flag at all.
- **Extended mode** (`extMode` = 1): every fatal stack error that forces the emergency stack sets bit 2, whatever caused it.

The stack-limit comparator, the trap sequencer and the memory-management unit all sit outside this block. They only deliver strobes to it.

Top module: `trap_cause_reg`

## Requirements
- R1: Flag positions in `rdData` are: bit 7 illegal halt (`evIllHalt`), bit 6 odd address (`evOddAddr`), bit 5 non-existent memory (`evNxm`), bit 4 bus timeout (`evTimeout`), bit 3 yellow-zone stack (`evYellow`), bit 2 red-zone stack. A strobe sets its bit on the next clock edge. Bits 15..8, 1 and 0 always read 0.
- R2: In either mode, `evRedLimit` sets bit 2 on the next edge.
- R3: In strict mode, `evFatalStack` without `evRedLimit` leaves bit 2 unchanged. A cause strobe in the same cycle (for example `evOddAddr`) still sets its own bit.
- R4: In strict mode, a cycle with `evFatalMmu` high and `evRedLimit` low changes no flag, even if other cause strobes are also high in that cycle.
- R5: In extended mode, `evFatalStack` or `evFatalMmu` sets bit 2 on the next edge, together with any other cause strobes of that cycle.
- R6: Flags are sticky. While `wrEn` is low, no flag ever goes from 1 to 0.
- R7: `wrEn` high clears all six flags on the next edge. There is no write-data input.
- R8: When a set strobe and `wrEn` are high in the same cycle, the strobed flag reads 1 afterwards.
- R9: Synchronous reset (`rst` high at a clock edge) clears all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| extMode | input | 1 | Red-zone rule: 0 strict, 1 extended |
| evIllHalt | input | 1 | Illegal halt strobe |
| evOddAddr | input | 1 | Odd address strobe |
| evNxm | input | 1 | Non-existent memory strobe |
| evTimeout | input | 1 | Bus timeout strobe |
| evYellow | input | 1 | Yellow-zone stack warning strobe |
| evRedLimit | input | 1 | Red-zone stack-limit violation strobe |
| evFatalStack | input | 1 | Fatal stack escalation strobe |
| evFatalMmu | input | 1 | Escalation caused by memory management strobe |
| wrEn | input | 1 | Software write, clears all flags |
| rdData | output | 16 | Register read value |

## Verification
The assertions check on every cycle the rules that depend only on strobes and the previous register value:
- flags only rise while there is no write;
- the red-limit strobe always sets bit 2;
- a strict-mode memory-management escalation freezes the register;
- extended-mode escalations set bit 2;
- set wins over clear;
- the unused bits stay zero.

The bench scenarios show what a single cycle cannot. They give the final register contents for the four event mixes in both modes: a pure red violation, an odd-address escalation, a kernel memory-management stack abort and a yellow warning. They also show that flags accumulate across separate events and that reset and writes return the register to zero.

// File: rtl/trap_cause_pkg.sv
package trap_cause_pkg;
  localparam int CAUSE_N = 6;

  // Command from control to datapath; setMask bit 0 is the red-zone flag
  typedef struct packed {
    logic [CAUSE_N-1:0] setMask;
    logic               clrAll;
  } flagCmd_t;
endpackage

// File: rtl/trap_cause_ctrl.sv
module trap_cause_ctrl
  import trap_cause_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     extMode,
  input  logic     evIllHalt,
  input  logic     evOddAddr,
  input  logic     evNxm,
  input  logic     evTimeout,
  input  logic     evYellow,
  input  logic     evRedLimit,
  input  logic     evFatalStack,
  input  logic     evFatalMmu,
  input  logic     wrEn,
  output flagCmd_t cmd
);
  logic               redHit;
  logic               mmuQuiet;
  logic [CAUSE_N-1:0] rawMask;

  always_comb begin
    // red flag: limit violation always, escalations only in extended mode
    redHit   = evRedLimit | (extMode & (evFatalStack | evFatalMmu));
    rawMask  = {evIllHalt, evOddAddr, evNxm, evTimeout, evYellow, redHit};
    // strict mode: an MMU-driven escalation records nothing (unless it is a limit hit)
    mmuQuiet = !extMode && evFatalMmu;
    cmd.setMask = mmuQuiet ? {{(CAUSE_N-1){1'b0}}, evRedLimit} : rawMask;
    cmd.clrAll  = wrEn;
  end

  // R3: strict-mode escalation alone never requests the red flag
  a_r3_strict_no_red: assert property (@(posedge clk) disable iff (rst)
    (!extMode && !evRedLimit) |-> !cmd.setMask[0]);
endmodule

// File: rtl/trap_cause_dp.sv
module trap_cause_dp
  import trap_cause_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int FLAG_LSB = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  flagCmd_t         cmd,
  output logic [REG_W-1:0] rdData
);
  localparam int FLAG_MSB = FLAG_LSB + CAUSE_N - 1;

  logic [CAUSE_N-1:0] flags;
  logic               chkArm;

  generate
    for (genvar i = 0; i < CAUSE_N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)                 flags[i] <= 1'b0;
        else if (cmd.setMask[i]) flags[i] <= 1'b1;   // set beats clear
        else if (cmd.clrAll)     flags[i] <= 1'b0;
      end

      // R8: a requested set is visible after the edge even during a write
      a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        cmd.setMask[i] |=> flags[i]);
    end
  endgenerate

  always_comb begin
    rdData = '0;
    rdData[FLAG_MSB:FLAG_LSB] = flags;
  end

  always_ff @(posedge clk) chkArm <= !rst;

  // R6: without a write, no flag falls
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst || !chkArm)
    !$past(cmd.clrAll) |-> (($past(flags) & ~flags) == '0));

  // R7: a write with no set request empties the register
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (cmd.clrAll && cmd.setMask == '0) |=> (flags == '0));
endmodule

// File: rtl/trap_cause_reg.sv
module trap_cause_reg
  import trap_cause_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int FLAG_LSB = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             extMode,
  input  logic             evIllHalt,
  input  logic             evOddAddr,
  input  logic             evNxm,
  input  logic             evTimeout,
  input  logic             evYellow,
  input  logic             evRedLimit,
  input  logic             evFatalStack,
  input  logic             evFatalMmu,
  input  logic             wrEn,
  output logic [REG_W-1:0] rdData
);
  localparam logic [REG_W-1:0] LIVE_MASK = ((REG_W)'((1 << CAUSE_N) - 1)) << FLAG_LSB;

  flagCmd_t cmd;
  logic     chkArm;

  trap_cause_ctrl ctrl_i (
    .clk, .rst, .extMode, .evIllHalt, .evOddAddr, .evNxm, .evTimeout,
    .evYellow, .evRedLimit, .evFatalStack, .evFatalMmu, .wrEn, .cmd
  );

  trap_cause_dp #(.REG_W(REG_W), .FLAG_LSB(FLAG_LSB)) dp_i (
    .clk, .rst, .cmd, .rdData
  );

  always_ff @(posedge clk) chkArm <= !rst;

  // R1: unused bits read zero
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (rst || !chkArm)
    (rdData & ~LIVE_MASK) == '0);

  // R2: red-limit strobe sets the red flag in both modes
  a_r2_red_limit: assert property (@(posedge clk) disable iff (rst)
    evRedLimit |=> rdData[FLAG_LSB]);

  // R4: strict-mode MMU escalation freezes the register
  a_r4_mmu_quiet: assert property (@(posedge clk) disable iff (rst || !chkArm)
    (!extMode && evFatalMmu && !evRedLimit && !wrEn) |=> $stable(rdData));

  // R5: extended mode flags every escalation as red
  a_r5_ext_red: assert property (@(posedge clk) disable iff (rst)
    (extMode && (evFatalStack || evFatalMmu)) |=> rdData[FLAG_LSB]);

  // R9: reset empties the register
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (rdData == '0));
endmodule

// File: tb/trap_cause_reg_tb_top.sv
module trap_cause_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        extMode = 1'b0;
  logic        evIllHalt = 0, evOddAddr = 0, evNxm = 0, evTimeout = 0;
  logic        evYellow = 0, evRedLimit = 0, evFatalStack = 0, evFatalMmu = 0;
  logic        wrEn = 1'b0;
  logic [15:0] rdData;
  int          nRun = 0;
  int          nFail = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  trap_cause_reg dut_i (
    .clk, .rst, .extMode, .evIllHalt, .evOddAddr, .evNxm, .evTimeout,
    .evYellow, .evRedLimit, .evFatalStack, .evFatalMmu, .wrEn, .rdData
  );

  // stimulus byte: {halt, odd, nxm, tmo, yellow, redLimit, fatal, mmu}
  localparam int NV = 13;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'b0000_0110, 16'h0004},  // R2 strict pure red
    {1'b0, 8'b0100_0010, 16'h0040},  // R3 strict odd escalation
    {1'b0, 8'b0000_0011, 16'h0000},  // R4 strict mmu abort
    {1'b0, 8'b0000_1000, 16'h0008},  // R1 strict yellow
    {1'b1, 8'b0000_0110, 16'h0004},  // R2 ext pure red
    {1'b1, 8'b0100_0010, 16'h0044},  // R5 ext odd escalation
    {1'b1, 8'b0000_0011, 16'h0004},  // R5 ext mmu abort
    {1'b1, 8'b0000_1000, 16'h0008},  // R1 ext yellow
    {1'b0, 8'b1000_0000, 16'h0080},  // R1 halt
    {1'b0, 8'b0010_0000, 16'h0020},  // R1 nxm
    {1'b0, 8'b0001_0000, 16'h0010},  // R1 timeout
    {1'b0, 8'b0100_0011, 16'h0000},  // R4 strict mmu with odd
    {1'b1, 8'b0000_0010, 16'h0004}   // R5 ext fatal only
  };

  task automatic check(input string req, input logic [15:0] exp);
    nRun++;
    if (rdData !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, rdData, exp);
    end
  endtask

  // drive on negedge, held for one posedge, sampled at the following negedge
  task automatic pulse(input logic [7:0] s, input logic wr);
    {evIllHalt, evOddAddr, evNxm, evTimeout, evYellow, evRedLimit, evFatalStack, evFatalMmu} = s;
    wrEn = wr;
    @(negedge clk);
    {evIllHalt, evOddAddr, evNxm, evTimeout, evYellow, evRedLimit, evFatalStack, evFatalMmu} = '0;
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 reset", 16'h0000);
    for (int i = 0; i < NV; i++) begin
      pulse(8'h00, 1'b1);
      extMode = VEC[i][24];
      pulse(VEC[i][23:16], 1'b0);
      check($sformatf("R1-table vec%0d (R2 R3 R4 R5)", i), VEC[i][15:0]);
    end
    // R6 sticky accumulation across separate events
    extMode = 1'b0;
    pulse(8'h00, 1'b1);
    pulse(8'b0001_0000, 1'b0);
    pulse(8'b0000_1000, 1'b0);
    pulse(8'h00, 1'b0);
    check("R6 sticky", 16'h0018);
    // R4 MMU escalation leaves earlier flags alone
    pulse(8'b1000_0011, 1'b0);
    check("R4 frozen", 16'h0018);
    // R7 write clears everything
    pulse(8'h00, 1'b1);
    check("R7 clear", 16'h0000);
    // R8 set beats clear
    pulse(8'b0100_0000, 1'b0);
    pulse(8'b0010_0000, 1'b1);
    check("R8 set wins", 16'h0020);
    // R3 strict fatal alone keeps red clear
    pulse(8'b0000_0010, 1'b0);
    check("R3 strict fatal", 16'h0020);
    // R9 reset mid-run
    pulse(8'b1111_1100, 1'b0);
    check("R1 all set", 16'h00FC);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset mid-run", 16'h0000);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule